// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits beside a BCD timekeeper and decides when the hour has to jump for daylight saving time. Software programs eight control bytes through a small write port. They describe two boundaries, one to start saving time (forward) and one to end it (reverse). Each boundary gives a month, a day and an hour. The day is picked either by a calendar date or by a week-of-month plus day-of-week pair, and a per-boundary priority bit chooses between the two rules.

On every one-second tick the block compares the clock fields it receives with both boundaries. When the forward boundary is reached, it sends a one-cycle command to advance the hour and raises the in-effect flag. When the reverse boundary is reached while that flag is set, it sends a one-cycle command to retard the hour and drops the flag. Because the flag is already low when the repeated hour reaches the boundary again, that second pass causes no further adjustment.

The enable bit must have been set before the final hour preceding the forward change. Clearing the enable bit drops the flag at once.

The controller has four states:
- `ST_OFF`: the enable bit is clear.
- `ST_WAIT`: enabled, but not yet qualified.
- `ST_STD`: armed, standard time.
- `ST_DST`: saving time in effect.

The transitions are:
- OFF→WAIT: a write that sets the enable bit.
- WAIT→STD: a tick that falls outside both the lead hour and the forward boundary.
- STD→DST: a tick at the forward boundary.
- DST→STD: a tick at the reverse boundary.
- any→OFF: a write that clears the enable bit. This transition takes precedence over all others.

Top module: `dst_adjuster`

## Requirements
- R1: After reset, `hour_fwd`, `hour_back` and `dst_active` are 0 and all eight control bytes are 00h (controller in `ST_OFF`).
- R2: Register layout. The forward set sits at addresses 0–3 and the reverse set at 4–7, with the same field positions in both sets.
  - Byte 0 holds the month in BCD in bits 4:0. Bit 7 of address 0 is the enable bit; bit 7 of address 4 is unused.
  - Byte 1 is the day selector: bit 7 is the priority bit, bits 5:3 are the week of month (1–5), and bits 2:0 are the day of week (0–6).
  - Byte 2 is the date in BCD, in bits 5:0.
  - Byte 3 is the hour in 24-hour BCD, in bits 5:0.
- R3: A tick at the forward boundary (month, day rule and hour match, minute 00, second 00) while armed in standard time produces a single `hour_fwd` pulse. The pulse appears in the cycle after the tick edge, and `dst_active` is 1 from that same cycle on.
- R4: With the priority bit 0, the day matches only when the clock date equals the programmed date; the clock day of week is ignored.
- R5: With the priority bit 1, the day matches when the clock day of week equals the programmed day of week and the clock's week of month, (date−1)/7+1, equals the programmed week. The programmed date is ignored.
- R6: A tick at the reverse boundary while `dst_active` is 1 produces a single `hour_back` pulse one cycle later and clears `dst_active`. A tick at the reverse boundary while `dst_active` is 0 produces no pulse.
- R7: Writing address 0 with bit 7 = 0 clears `dst_active` in the next cycle and blocks all pulses until re-armed. This write wins over a boundary tick in the same cycle.
- R8: After the enable bit is set, no forward change occurs until at least one tick has been seen outside the lead hour. The lead hour is the hour before the programmed forward hour, on the forward day. A tick at the boundary itself does not arm the block.
- R9: Pulses occur only on a `sec_tick` cycle. A boundary hour with a nonzero minute produces no pulse.
- R10: A tick at the forward boundary while `dst_active` is already 1 produces no `hour_fwd` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second; clock fields are valid with it |
| cur_month | input | 8 | Clock month, BCD 01–12 |
| cur_date | input | 8 | Clock date, BCD 01–31 |
| cur_dow | input | 3 | Clock day of week, 0–6 |
| cur_hour | input | 8 | Clock hour, BCD 00–23 |
| cur_min | input | 8 | Clock minute, BCD |
| cur_sec | input | 8 | Clock second, BCD |
| wr_en | input | 1 | Control byte write strobe |
| wr_addr | input | 3 | Control byte address 0–7 |
| wr_data | input | 8 | Control byte write data |
| hour_fwd | output | 1 | One-cycle command: advance hour by one |
| hour_back | output | 1 | One-cycle command: retard hour by one |
| dst_active | output | 1 | Saving time currently in effect |

## Verification
The two functions that can coincide are a write that clears the enable bit and a second tick that lands on a boundary. The bench provokes this by issuing the disabling write to address 0 in the same cycle as a tick at the reverse boundary while saving time is active. The expected result is that the write wins: no `hour_back` pulse appears and `dst_active` reads 0 in the following cycle. A design that favours the boundary would show a retard pulse instead.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int BYTE_W     = 8;
    localparam int RULE_BYTES = 4;
    localparam int NUM_RULES  = 2;
    localparam int NUM_REGS   = RULE_BYTES * NUM_RULES;
    localparam int ADDR_W     = $clog2(NUM_REGS);
    localparam int BIN_W      = 7;
    localparam int FWD        = 0;
    localparam int REV        = 1;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_STD  = 2'd2,
        ST_DST  = 2'd3
    } dst_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] daysel;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] hour;
    } dst_rule_t;

    function automatic logic [BIN_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
        logic [BIN_W-1:0] tens;
        tens = {3'b000, b[7:4]};
        return (tens * 7'd10) + {3'b000, b[3:0]};
    endfunction

endpackage

// File: rtl/dst_regs.sv
module dst_regs
    import dst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output dst_rule_t         rules [NUM_RULES],
    output logic              en_set,
    output logic              en_clr
);

    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_addr] <= wr_data;
        end
    end

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_rule
        assign rules[g] = '{
            month:  regs_q[g*RULE_BYTES + 0],
            daysel: regs_q[g*RULE_BYTES + 1],
            date:   regs_q[g*RULE_BYTES + 2],
            hour:   regs_q[g*RULE_BYTES + 3]
        };
    end

    always_comb begin
        en_set = wr_en && (wr_addr == '0) &&  wr_data[BYTE_W-1];
        en_clr = wr_en && (wr_addr == '0) && !wr_data[BYTE_W-1];
    end

endmodule

// File: rtl/dst_match.sv
module dst_match
    import dst_pkg::*;
(
    input  dst_rule_t         rule,
    input  logic [BYTE_W-1:0] cur_month,
    input  logic [BYTE_W-1:0] cur_date,
    input  logic [2:0]        cur_dow,
    input  logic [BYTE_W-1:0] cur_hour,
    input  logic [BYTE_W-1:0] cur_min,
    input  logic [BYTE_W-1:0] cur_sec,
    output logic              hit,
    output logic              lead
);

    logic [BIN_W-1:0] date_bin;
    logic [BIN_W-1:0] hr_bin;
    logic [BIN_W-1:0] bh_bin;
    logic [2:0]       week_cur;
    logic             month_ok;
    logic             day_ok;
    logic             prio;

    always_comb begin
        date_bin = bcd_to_bin(cur_date);
        hr_bin   = bcd_to_bin(cur_hour);
        bh_bin   = bcd_to_bin({2'b00, rule.hour[5:0]});
        week_cur = (date_bin == '0) ? 3'd0
                                    : 3'(((date_bin - 7'd1) / 7'd7) + 7'd1);
        prio     = rule.daysel[7];
        month_ok = (cur_month == {3'b000, rule.month[4:0]});
        if (prio)
            day_ok = (cur_dow == rule.daysel[2:0]) && (week_cur == rule.daysel[5:3]);
        else
            day_ok = (cur_date == {2'b00, rule.date[5:0]});
        hit  = month_ok && day_ok
            && (cur_hour == {2'b00, rule.hour[5:0]})
            && (cur_min == '0) && (cur_sec == '0);
        lead = month_ok && day_ok && (bh_bin != '0) && (hr_bin == bh_bin - 7'd1);
    end

endmodule

// File: rtl/dst_fsm.sv
module dst_fsm
    import dst_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sec_tick,
    input  logic                 en_set,
    input  logic                 en_clr,
    input  logic [NUM_RULES-1:0] hit,
    input  logic [NUM_RULES-1:0] lead,
    output logic                 hour_fwd,
    output logic                 hour_back,
    output logic                 dst_active
);

    dst_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (en_set)                                  state_d = ST_WAIT;
            ST_WAIT: if (sec_tick && !lead[FWD] && !hit[FWD])     state_d = ST_STD;
            ST_STD:  if (sec_tick && hit[FWD])                    state_d = ST_DST;
            ST_DST:  if (sec_tick && hit[REV])                    state_d = ST_STD;
            default:                                              state_d = ST_OFF;
        endcase
        if (en_clr) state_d = ST_OFF;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hour_fwd  <= 1'b0;
            hour_back <= 1'b0;
        end else begin
            hour_fwd  <= sec_tick && !en_clr && (state_q == ST_STD) && hit[FWD];
            hour_back <= sec_tick && !en_clr && (state_q == ST_DST) && hit[REV];
        end
    end

    assign dst_active = (state_q == ST_DST);

    AST_FWD_SETS_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) hour_fwd |-> dst_active); // R3
    AST_BACK_CLR_FLAG:   assert property (@(posedge clk) disable iff (!rst_n) hour_back |-> !dst_active); // R6
    AST_BACK_FROM_DST:   assert property (@(posedge clk) disable iff (!rst_n) hour_back |-> $past(dst_active)); // R6
    AST_DISABLE_WINS:    assert property (@(posedge clk) disable iff (!rst_n) en_clr |=> (!dst_active && !hour_fwd && !hour_back)); // R7
    AST_PULSE_ON_TICK:   assert property (@(posedge clk) disable iff (!rst_n) (hour_fwd || hour_back) |-> $past(sec_tick)); // R9
    AST_NO_FWD_IN_DST:   assert property (@(posedge clk) disable iff (!rst_n) hour_fwd |-> !$past(dst_active)); // R10
    AST_PULSES_EXCL:     assert property (@(posedge clk) disable iff (!rst_n) $onehot0({hour_fwd, hour_back})); // R3

endmodule

// File: rtl/dst_adjuster.sv
module dst_adjuster
    import dst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [7:0]        cur_month,
    input  logic [7:0]        cur_date,
    input  logic [2:0]        cur_dow,
    input  logic [7:0]        cur_hour,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_sec,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic              hour_fwd,
    output logic              hour_back,
    output logic              dst_active
);

    dst_rule_t              rules [NUM_RULES];
    logic                   en_set;
    logic                   en_clr;
    logic [NUM_RULES-1:0]   hit;
    logic [NUM_RULES-1:0]   lead;

    dst_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rules   (rules),
        .en_set  (en_set),
        .en_clr  (en_clr)
    );

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_match
        dst_match u_match (
            .rule      (rules[g]),
            .cur_month (cur_month),
            .cur_date  (cur_date),
            .cur_dow   (cur_dow),
            .cur_hour  (cur_hour),
            .cur_min   (cur_min),
            .cur_sec   (cur_sec),
            .hit       (hit[g]),
            .lead      (lead[g])
        );
    end

    dst_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_tick   (sec_tick),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .hit        (hit),
        .lead       (lead),
        .hour_fwd   (hour_fwd),
        .hour_back  (hour_back),
        .dst_active (dst_active)
    );

endmodule

// File: tb/dst_adjuster_tb_top.sv
module dst_adjuster_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] cur_month = '0, cur_date = '0, cur_hour = '0, cur_min = '0, cur_sec = '0;
    logic [2:0] cur_dow = '0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       hour_fwd, hour_back, dst_active;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  f;
        logic  b;
        logic  a;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    dst_adjuster dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_month(cur_month), .cur_date(cur_date), .cur_dow(cur_dow),
        .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hour_fwd(hour_fwd), .hour_back(hour_back), .dst_active(dst_active)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected items when their cycle comes and compares.
    always @(negedge clk) begin
        if (sb_q.size() > 0 && sb_q[0].at == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            n_checks++;
            if (hour_fwd !== e.f || hour_back !== e.b || dst_active !== e.a) begin
                n_fail++;
                $display("FAIL %s: got fwd=%b back=%b act=%b, expected fwd=%b back=%b act=%b",
                         e.tag, hour_fwd, hour_back, dst_active, e.f, e.b, e.a);
            end
        end
    end

    task automatic push_exp(input logic f, input logic b, input logic a, input string tag);
        exp_t e;
        e.at = cyc + 1; e.f = f; e.b = b; e.a = a; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [2:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: presents clock fields (with or without tick, optionally with a
    // same-cycle disabling write) and pushes the expected result.
    task automatic step(input logic [7:0] mo, input logic [7:0] dt, input logic [2:0] dw,
                        input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                        input logic tick, input logic dis,
                        input logic ef, input logic eb, input logic ea, input string tag);
        @(negedge clk);
        cur_month = mo; cur_date = dt; cur_dow = dw;
        cur_hour = hr; cur_min = mi; cur_sec = se;
        sec_tick = tick;
        if (dis) begin wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h03; end
        push_exp(ef, eb, ea, tag);
        @(negedge clk);
        sec_tick = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen at the ports
        step(8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R1 reset state");

        // R2: forward rule Mar, priority 1 week 2 dow 0, date 14, hour 02
        //     reverse rule Nov, priority 0, date 05, hour 02
        wr(3'd1, 8'h90);
        wr(3'd2, 8'h14);
        wr(3'd3, 8'h02);
        wr(3'd4, 8'h11);
        wr(3'd5, 8'h08);
        wr(3'd6, 8'h05);
        wr(3'd7, 8'h02);
        wr(3'd0, 8'h83);

        // R8: tick outside the lead hour arms the block
        step(8'h01, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, 0, "R8 arming tick");
        // R9: minute 01 at the boundary hour
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h01, 8'h00, 1, 0, 0, 0, 0, "R9 nonzero minute");
        // R5: programmed date 14 ignored when priority set (dow 6 mismatches)
        step(8'h03, 8'h14, 3'd6, 8'h02, 8'h00, 8'h00, 1, 0, 0, 0, 0, "R5 date ignored");
        // R9: boundary fields without a tick
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00, 0, 0, 0, 0, 0, "R9 no tick");
        // R3/R5: week (9-1)/7+1 = 2, dow 0 -> forward
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 1, 0, 1, "R3 forward boundary");
        // R10: boundary again while active
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 0, 0, 1, "R10 no second forward");
        // R4: date 06 with dow 0 does not match date 05
        step(8'h11, 8'h06, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 0, 0, 1, "R4 wrong date");
        // R4/R6: date 05, dow arbitrary -> reverse
        step(8'h11, 8'h05, 3'd3, 8'h02, 8'h00, 8'h00, 1, 0, 0, 1, 0, "R6 reverse boundary");
        // R6: repeated hour reaches the boundary again
        step(8'h11, 8'h05, 3'd3, 8'h02, 8'h00, 8'h00, 1, 0, 0, 0, 0, "R6 repeated hour");

        // R7: re-enter saving time then disable
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 1, 0, 1, "R3 forward again");
        step(8'h01, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00, 0, 1, 0, 0, 0, "R7 disable clears flag");
        step(8'h11, 8'h05, 3'd3, 8'h02, 8'h00, 8'h00, 1, 0, 0, 0, 0, "R7 disabled no pulse");

        // R8: enable inside the lead hour only
        wr(3'd0, 8'h83);
        step(8'h03, 8'h09, 3'd0, 8'h01, 8'h30, 8'h00, 1, 0, 0, 0, 0, "R8 lead-hour tick");
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 0, 0, 0, "R8 unarmed boundary");
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 0, 0, 0, "R8 boundary does not arm");
        step(8'h01, 8'h01, 3'd3, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, 0, "R8 arm later");
        step(8'h03, 8'h09, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 1, 0, 1, "R8 forward after arming");

        // R7: disable in the same cycle as a reverse boundary tick
        step(8'h11, 8'h05, 3'd3, 8'h02, 8'h00, 8'h00, 1, 1, 0, 0, 0, "R7 disable beats boundary");

        repeat (3) @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

endmodule